// File: doc/BRIEF.md
# Serial Port Interrupt Status and Mask Unit

This block gathers the interrupt events of a serial port into one place that software can inspect and control. Each of eleven event sources delivers a single-cycle pulse. The pulse sets a sticky bit in a raw status register. An enable register selects which sources may raise the combined interrupt. A masked view shows raw status ANDed with the enables. A write-only clear register lets software acknowledge sources by writing ones.

Access uses a plain register bus with no handshake. A write takes effect at the rising clock edge where `bus_we` is high. Read data is combinational from the current address and the current register state. No data stream passes through the block, so it has no valid/ready interface. The single interrupt output is the registered OR of all masked bits.

The bits are fixed. The byte offsets are 0x038 for the enable register, 0x03C for raw status, 0x040 for masked status and 0x044 for the clear register.

Each source is named by its bit position:

| Bit | Source |
|-----|--------|
| 10 | overrun error |
| 9 | line break |
| 8 | parity error |
| 7 | framing error |
| 6 | receive timeout |
| 5 | transmit level |
| 4 | receive level |
| 3 | DSR change |
| 2 | DCD change |
| 1 | CTS change |
| 0 | RI change |

Top module: `uart_irq_unit`

## Requirements
- R1: A pulse on `evt_pulse[i]` sets raw status bit i at that clock edge, and the bit stays set until it is cleared. The bit order is the one given in the table above.
- R2: A write to offset 0x038 loads bits 10:0 of `bus_wdata` into the enable register. A 1 enables a source and a 0 disables it. A read of 0x038 returns the current enables.
- R3: A read of offset 0x040 returns raw status ANDed bit by bit with the enable register.
- R4: A write to offset 0x044 clears every raw bit whose `bus_wdata` bit is 1. Raw bits whose `bus_wdata` bit is 0 keep their value.
- R5: When an event pulse and a clear of the same bit fall in the same cycle, the raw bit ends up set.
- R6: `irq_out` equals the OR of the masked status bits as they stood one cycle earlier.
- R7: Read data bits 15:11 are always zero. Reads of offset 0x044 return zero, and so do reads of any address other than 0x038, 0x03C and 0x040.
- R8: Writes to offsets 0x03C and 0x040, or to any unmapped address, change neither raw status nor the enable register.
- R9: After reset, raw status, the enable register and `irq_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 11 | One-cycle event pulses, one per source |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 11 | Write data, one bit per source |
| bus_rdata | output | 16 | Combinational read data |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
The bench builds the block with the default 12-bit address and 16-bit read data. With these widths, both the reserved read bits and the unmapped addresses near the four mapped offsets can be checked.

Random event pulses are mixed with random enable, clear and stray writes. This mix makes clears and events collide on the same bit, so the precedence of an event over a clear is exercised. The same mix checks the one-cycle lag of `irq_out` against a reference model for many combinations of raw status and enables.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned SRC_COUNT = 11;

  localparam int unsigned SRC_OVERRUN = 10;
  localparam int unsigned SRC_BREAK   = 9;
  localparam int unsigned SRC_PARITY  = 8;
  localparam int unsigned SRC_FRAMING = 7;
  localparam int unsigned SRC_RXTMO   = 6;
  localparam int unsigned SRC_TXLVL   = 5;
  localparam int unsigned SRC_RXLVL   = 4;
  localparam int unsigned SRC_DSR     = 3;
  localparam int unsigned SRC_DCD     = 2;
  localparam int unsigned SRC_CTS     = 1;
  localparam int unsigned SRC_RI      = 0;

  localparam int unsigned OFS_ENABLE = 'h038;
  localparam int unsigned OFS_RAW    = 'h03C;
  localparam int unsigned OFS_MASKED = 'h040;
  localparam int unsigned OFS_CLEAR  = 'h044;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_RAW,
    SEL_MASKED,
    SEL_CLEAR
  } reg_sel_e;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import uart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NSRC   = SRC_COUNT
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [NSRC-1:0]   wdata,
  input  logic [NSRC-1:0]   raw,
  input  logic [NSRC-1:0]   enables,
  input  logic [NSRC-1:0]   masked,
  output logic              enable_wr,
  output logic [NSRC-1:0]   clear_vec,
  output logic [DATA_W-1:0] rdata
);
  reg_sel_e sel;

  always_comb begin
    if (addr == ADDR_W'(OFS_ENABLE))      sel = SEL_ENABLE;
    else if (addr == ADDR_W'(OFS_RAW))    sel = SEL_RAW;
    else if (addr == ADDR_W'(OFS_MASKED)) sel = SEL_MASKED;
    else if (addr == ADDR_W'(OFS_CLEAR))  sel = SEL_CLEAR;
    else                                  sel = SEL_NONE;
  end

  assign enable_wr = we && (sel == SEL_ENABLE);
  assign clear_vec = (we && (sel == SEL_CLEAR)) ? wdata : '0;

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_ENABLE: rdata[NSRC-1:0] = enables;
      SEL_RAW:    rdata[NSRC-1:0] = raw;
      SEL_MASKED: rdata[NSRC-1:0] = masked;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_raw_bank.sv
module irq_raw_bank #(
  parameter int unsigned NSRC = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clear_vec,
  output logic [NSRC-1:0] raw
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            raw[i] <= 1'b0;
      else if (set_vec[i])   raw[i] <= 1'b1;
      else if (clear_vec[i]) raw[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned NSRC = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] enables
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  enables <= '0;
    else if (wr) enables <= wdata;
  end
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int unsigned NSRC = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] raw,
  input  logic [NSRC-1:0] enables,
  output logic [NSRC-1:0] masked,
  output logic            irq
);
  assign masked = raw & enables;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |masked;
  end
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SRC_COUNT-1:0] evt_pulse,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [SRC_COUNT-1:0] bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 irq_out
);
  localparam int unsigned NSRC = SRC_COUNT;

  logic [NSRC-1:0] raw_q;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] masked;
  logic [NSRC-1:0] clear_vec;
  logic            enable_wr;

  irq_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSRC(NSRC)) u_decode (
    .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .raw(raw_q), .enables(mask_q), .masked(masked),
    .enable_wr(enable_wr), .clear_vec(clear_vec), .rdata(bus_rdata)
  );

  irq_raw_bank #(.NSRC(NSRC)) u_raw (
    .clk(clk), .rst_n(rst_n), .set_vec(evt_pulse),
    .clear_vec(clear_vec), .raw(raw_q)
  );

  irq_enable_reg #(.NSRC(NSRC)) u_enable (
    .clk(clk), .rst_n(rst_n), .wr(enable_wr),
    .wdata(bus_wdata), .enables(mask_q)
  );

  irq_combine #(.NSRC(NSRC)) u_combine (
    .clk(clk), .rst_n(rst_n), .raw(raw_q), .enables(mask_q),
    .masked(masked), .irq(irq_out)
  );
endmodule

// File: rtl/uart_irq_unit_chk.sv
module uart_irq_unit_chk
  import uart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [SRC_COUNT-1:0] evt_pulse,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_we,
  input logic [SRC_COUNT-1:0] bus_wdata,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic                 irq_out,
  input logic [SRC_COUNT-1:0] raw_q,
  input logic [SRC_COUNT-1:0] mask_q
);
  logic clr_wr;
  logic en_wr;
  assign clr_wr = bus_we && (bus_addr == ADDR_W'(OFS_CLEAR));
  assign en_wr  = bus_we && (bus_addr == ADDR_W'(OFS_ENABLE));

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |=> ((raw_q & $past(evt_pulse)) == $past(evt_pulse))); // R5

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((raw_q & $past(bus_wdata & ~evt_pulse)) == '0)); // R4

  AST_RAW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && evt_pulse == '0) |=> $stable(raw_q)); // R8

  AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(mask_q)); // R2

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == $past(|(raw_q & mask_q))); // R6

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:SRC_COUNT] == '0); // R7

  AST_MASKED_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFS_MASKED)) |-> (bus_rdata[SRC_COUNT-1:0] == (raw_q & mask_q))); // R3
endmodule

bind uart_irq_unit uart_irq_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .bus_addr(bus_addr),
  .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_out(irq_out), .raw_q(raw_q), .mask_q(mask_q)
);

// File: tb/uart_irq_unit_bench.sv
module uart_irq_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int NS = 11;
  localparam logic [AW-1:0] A_EN  = 12'h038;
  localparam logic [AW-1:0] A_RAW = 12'h03C;
  localparam logic [AW-1:0] A_MIS = 12'h040;
  localparam logic [AW-1:0] A_CLR = 12'h044;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] evt_pulse = '0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [NS-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [NS-1:0] m_raw = '0;
  logic [NS-1:0] m_en = '0;
  logic m_irq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_unit #(.ADDR_W(AW), .DATA_W(DW)) u_uart_irq_unit (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a);
    logic [DW-1:0] r = '0;
    if (a == A_EN)       r[NS-1:0] = m_en;
    else if (a == A_RAW) r[NS-1:0] = m_raw;
    else if (a == A_MIS) r[NS-1:0] = m_raw & m_en;
    return r;
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, advance one edge, update model, return at next negedge
  task automatic step(logic [NS-1:0] evt, logic [AW-1:0] a, logic we, logic [NS-1:0] wd);
    logic [NS-1:0] clr;
    evt_pulse = evt; bus_addr = a; bus_we = we; bus_wdata = wd;
    @(posedge clk);
    clr = (we && a == A_CLR) ? wd : '0;
    m_irq = |(m_raw & m_en);
    m_raw = (m_raw & ~clr) | evt;
    if (we && a == A_EN) m_en = wd;
    @(negedge clk);
    evt_pulse = '0; bus_we = 1'b0;
  endtask

  task automatic rd(string tag, logic [AW-1:0] a);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp_read(a));
  endtask

  initial begin
    logic [NS-1:0] v;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    rd("R9 enable", A_EN); rd("R9 raw", A_RAW); rd("R9 masked", A_MIS);
    check("R9 irq", {15'd0, irq_out}, 16'd0);

    // R1 bit order: each source alone
    for (int i = 0; i < NS; i++) begin
      step(11'(1) << i, A_RAW, 1'b0, '0);
      check("R1 single source", bus_rdata, 16'(1) << i);
      step('0, A_CLR, 1'b1, '1);
    end
    step(11'h400, A_RAW, 1'b0, '0);
    check("R1 overrun at bit 10", bus_rdata, 16'h0400);
    step('0, A_CLR, 1'b1, '1);

    // R2 enable write/readback, R7 reserved bits
    step('0, A_EN, 1'b1, 11'h7FF); rd("R2 enable all", A_EN);
    check("R7 reserved bits", {bus_rdata[15:11], 11'd0}, 16'd0);
    step('0, A_EN, 1'b1, 11'h0A5); rd("R2 enable pattern", A_EN);

    // R3 masked view
    step(11'h0F0, A_MIS, 1'b0, '0); rd("R3 masked", A_MIS); rd("R3 raw", A_RAW);

    // R4 clear with zeros, then selective
    step('0, A_CLR, 1'b1, 11'h000); rd("R4 zero clear no effect", A_RAW);
    check("R4 raw kept", bus_rdata, 16'h00F0);
    step('0, A_CLR, 1'b1, 11'h030); rd("R4 selective clear", A_RAW);
    check("R4 raw after clear", bus_rdata, 16'h00C0);

    // R5 event beats clear
    step(11'h040, A_CLR, 1'b1, 11'h0C0); rd("R5 collision", A_RAW);
    check("R5 bit6 kept", bus_rdata, 16'h0040);
    step('0, A_CLR, 1'b1, '1);

    // R6 irq lag
    step('0, A_EN, 1'b1, 11'h001);
    step(11'h001, A_RAW, 1'b0, '0);
    check("R6 irq not yet", {15'd0, irq_out}, 16'd0);
    step('0, A_RAW, 1'b0, '0);
    check("R6 irq one cycle later", {15'd0, irq_out}, 16'd1);
    step('0, A_CLR, 1'b1, 11'h001);
    check("R6 irq still high", {15'd0, irq_out}, 16'd1);
    step('0, A_RAW, 1'b0, '0);
    check("R6 irq drops", {15'd0, irq_out}, 16'd0);

    // R7 clear and unmapped reads
    step(11'h3FF, A_RAW, 1'b0, '0);
    rd("R7 clear reads zero", A_CLR); check("R7 clr zero", bus_rdata, 16'd0);
    rd("R7 unmapped", 12'h048); rd("R7 unmapped low", 12'h000);

    // R8 writes to read-only and unmapped offsets
    step('0, A_RAW, 1'b1, 11'h000); step('0, A_MIS, 1'b1, 11'h000);
    step('0, 12'h034, 1'b1, 11'h000);
    rd("R8 raw unchanged", A_RAW); check("R8 raw value", bus_rdata, 16'h03FF);
    rd("R8 enable unchanged", A_EN); check("R8 enable value", bus_rdata, 16'h0001);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a;
      int k;
      k = $urandom_range(0, 5);
      case (k)
        0: a = A_EN; 1: a = A_RAW; 2: a = A_MIS; 3: a = A_CLR;
        4: a = 12'h048; default: a = 12'h03D;
      endcase
      v = 11'($urandom & $urandom & $urandom);
      step(v, a, ($urandom_range(0, 2) == 0), 11'($urandom));
      rd("R3 random read", a);
      check("R6 random irq", {15'd0, irq_out}, {15'd0, m_irq});
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule